// File: doc/BRIEF.md
# Coalescing Masked Store Buffer

This block sits between a CPU core's store path and its data cache. It holds a small, fixed number of pending line-sized entries. Each entry keeps the bits the core has written to one cache line, plus a mask of the same width that marks which of those bits are valid. A store to a line that is not held locally does not stall the core. The store is written into a free entry, and the block asks the coherence side for the line with a read-invalidate request. Later stores to the same line are folded into that same entry.

When the coherence side returns the full line, the block lays the masked bits of the entry over it. Every unmasked bit of the returned line passes through unchanged. The merged line goes out on the cache write port one cycle later, and the entry is released. The core therefore never has to know the parts of the line it did not write.

Top module: `sb_coalesce`

## Requirements
- R1: Each byte-enable bit `st_be[b]` that is set marks the eight line bits `8*b+7 .. 8*b` as written. A single-byte store of 0x5a with `st_be` = 4'b0001, followed by a fill carrying 0x11223344, writes 0x1122335a to the cache.
- R2: A store whose line address matches a pending entry is merged into that entry. It does not allocate a second entry and does not raise another read-invalidate request.
- R3: A later store to a byte that an entry already holds replaces the earlier data for that byte. Bytes written earlier and not covered by the new store keep their values.
- R4: A store that matches no entry and finds a free entry is accepted. From the cycle after acceptance, `ri_valid` is high with `ri_addr` equal to the store's line address, and it stays high until `ri_ready` is seen.
- R5: Each allocated entry issues exactly one read-invalidate request. After the handshake, `ri_valid` does not rise again for that entry.
- R6: A fill whose `fill_addr` matches an entry causes one cycle later `cw_valid` = 1, with `cw_addr` = `fill_addr` and `cw_line` = (fill line with the entry's masked bits overlaid).
- R7: The entry is freed by the fill that merged it. A second fill to the same address then produces no cache write.
- R8: A fill that matches no entry is ignored: no cache write follows, and the pending entries are kept.
- R9: When every entry is in use, `st_ready` is low for a store address that matches no entry and high for one that matches. `st_ready` rises again in the cycle after a fill frees an entry.
- R10: A store and a fill to the same pending line in the same cycle are applied store-first. The cache write contains the new store's bytes, and no entry remains for that line afterwards.
- R11: After reset, `st_ready` = 1, `ri_valid` = 0 and `cw_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | 32 | Line address of the store |
| st_data | input | 32 | Store data, aligned to the line |
| st_be | input | 4 | Per-byte write enables |
| ri_valid | output | 1 | Read-invalidate request present |
| ri_ready | input | 1 | Coherence side takes the request |
| ri_addr | output | 32 | Line address requested |
| fill_valid | input | 1 | Returned line present |
| fill_addr | input | 32 | Line address of the returned line |
| fill_line | input | 32 | Full returned line |
| cw_valid | output | 1 | Cache write present |
| cw_addr | output | 32 | Line address of the cache write |
| cw_line | output | 32 | Merged line to write |

## Verification
The bench checks bytes that are overwritten inside one entry. A design that kept the old byte, or cleared neighbouring mask bits, would write a wrong line. It checks fills for unknown lines and repeated fills. A design that accepted these would emit spurious cache writes or drop live entries. It checks the full buffer, where a design that ignored the miss-or-hit distinction would lose a store or refuse a mergeable one. It also checks a store racing a fill to the same line. Here a fill-first design would either leave the new bytes out of the written line or leave a stale entry behind, and a second fill exposes the stale entry.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_LINE_W = 32;
    localparam int SB_ADDR_W = 32;

    typedef struct packed {
        logic                 used;
        logic                 asked;
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_LINE_W-1:0] data;
        logic [SB_LINE_W-1:0] mask;
    } sb_entry_t;
endpackage

// File: rtl/sb_match.sv
module sb_match #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0]             used,
    input  logic [N_ENT-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]            probe,
    output logic [N_ENT-1:0]             hit_vec,
    output logic                         hit_any,
    output logic [IDX_W-1:0]             hit_idx
);
    for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
        assign hit_vec[i] = used[i] && (tags[i] == probe);
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sb_pick.sv
module sb_pick #(
    parameter int N_ENT  = 4,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/sb_overlay.sv
module sb_overlay #(
    parameter int LINE_W = 32
) (
    input  logic [LINE_W-1:0] base,
    input  logic [LINE_W-1:0] data,
    input  logic [LINE_W-1:0] mask,
    output logic [LINE_W-1:0] merged
);
    for (genvar b = 0; b < LINE_W; b++) begin : g_bit
        assign merged[b] = mask[b] ? data[b] : base[b];
    end
endmodule

// File: rtl/sb_coalesce.sv
module sb_coalesce
    import sb_pkg::*;
#(
    parameter int N_ENT  = 4,
    localparam int LINE_W = SB_LINE_W,
    localparam int ADDR_W = SB_ADDR_W,
    localparam int BE_W   = LINE_W / 8,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [LINE_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              ri_valid,
    input  logic              ri_ready,
    output logic [ADDR_W-1:0] ri_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [LINE_W-1:0] fill_line,
    output logic              cw_valid,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [LINE_W-1:0] cw_line
);
    typedef struct packed {
        sb_entry_t [N_ENT-1:0] ent;
        logic                  cw_valid;
        logic [ADDR_W-1:0]     cw_addr;
        logic [LINE_W-1:0]     cw_line;
    } state_t;

    state_t state_d, state_q;

    logic [N_ENT-1:0]             ent_used;
    logic [N_ENT-1:0]             ent_pending;
    logic [N_ENT-1:0][ADDR_W-1:0] ent_tags;
    logic [LINE_W-1:0]            st_bm;

    for (genvar i = 0; i < N_ENT; i++) begin : g_view
        assign ent_used[i]    = state_q.ent[i].used;
        assign ent_pending[i] = state_q.ent[i].used && !state_q.ent[i].asked;
        assign ent_tags[i]    = state_q.ent[i].addr;
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_bm
        assign st_bm[b*8 +: 8] = {8{st_be[b]}};
    end

    logic [N_ENT-1:0] st_hit_vec;
    logic             st_hit;
    logic [IDX_W-1:0] st_hit_idx;
    logic [N_ENT-1:0] fl_hit_vec;
    logic             fl_hit;
    logic [IDX_W-1:0] fl_hit_idx;

    sb_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_st_match (
        .used(ent_used), .tags(ent_tags), .probe(st_addr),
        .hit_vec(st_hit_vec), .hit_any(st_hit), .hit_idx(st_hit_idx)
    );

    sb_match #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_fl_match (
        .used(ent_used), .tags(ent_tags), .probe(fill_addr),
        .hit_vec(fl_hit_vec), .hit_any(fl_hit), .hit_idx(fl_hit_idx)
    );

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic             req_found;
    logic [IDX_W-1:0] req_idx;

    sb_pick #(.N_ENT(N_ENT)) u_free_pick (
        .cand(~ent_used), .found(free_found), .idx(free_idx)
    );

    sb_pick #(.N_ENT(N_ENT)) u_req_pick (
        .cand(ent_pending), .found(req_found), .idx(req_idx)
    );

    logic st_fire;
    assign st_ready = st_hit || free_found;
    assign st_fire  = st_valid && st_ready;
    assign ri_valid = req_found;
    assign ri_addr  = state_q.ent[req_idx].addr;

    // Store lands first when it targets the entry being filled.
    logic              same_line;
    logic [LINE_W-1:0] fl_data_eff;
    logic [LINE_W-1:0] fl_mask_eff;
    logic [LINE_W-1:0] fl_merged;

    assign same_line   = st_fire && st_hit && (st_hit_idx == fl_hit_idx);
    assign fl_data_eff = same_line
                       ? ((state_q.ent[fl_hit_idx].data & ~st_bm) | (st_data & st_bm))
                       : state_q.ent[fl_hit_idx].data;
    assign fl_mask_eff = same_line
                       ? (state_q.ent[fl_hit_idx].mask | st_bm)
                       : state_q.ent[fl_hit_idx].mask;

    sb_overlay #(.LINE_W(LINE_W)) u_overlay (
        .base(fill_line), .data(fl_data_eff), .mask(fl_mask_eff), .merged(fl_merged)
    );

    always_comb begin
        state_d          = state_q;
        state_d.cw_valid = 1'b0;

        if (st_fire) begin
            if (st_hit) begin
                state_d.ent[st_hit_idx].data =
                    (state_q.ent[st_hit_idx].data & ~st_bm) | (st_data & st_bm);
                state_d.ent[st_hit_idx].mask = state_q.ent[st_hit_idx].mask | st_bm;
            end else begin
                state_d.ent[free_idx].used  = 1'b1;
                state_d.ent[free_idx].asked = 1'b0;
                state_d.ent[free_idx].addr  = st_addr;
                state_d.ent[free_idx].data  = st_data & st_bm;
                state_d.ent[free_idx].mask  = st_bm;
            end
        end

        if (req_found && ri_ready) begin
            state_d.ent[req_idx].asked = 1'b1;
        end

        if (fill_valid && fl_hit) begin
            state_d.cw_valid                = 1'b1;
            state_d.cw_addr                 = fill_addr;
            state_d.cw_line                 = fl_merged;
            state_d.ent[fl_hit_idx].used    = 1'b0;
            state_d.ent[fl_hit_idx].asked   = 1'b0;
            state_d.ent[fl_hit_idx].mask    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cw_valid = state_q.cw_valid;
    assign cw_addr  = state_q.cw_addr;
    assign cw_line  = state_q.cw_line;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int N_ENT  = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_ready,
    input logic              ri_valid,
    input logic              ri_ready,
    input logic [ADDR_W-1:0] ri_addr,
    input logic              fill_valid,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              cw_valid,
    input logic [ADDR_W-1:0] cw_addr,
    input logic [N_ENT-1:0]  used_vec,
    input logic [N_ENT-1:0]  st_hit_vec
);
    // R2: a line never lives in two entries
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit_vec));

    // R9: refusing a store only when every entry is taken
    a_r9_full_only: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> ($countones(used_vec) == N_ENT));

    // R6: a cache write follows only a fill
    a_r6_write_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> !cw_valid);

    // R6: the written line carries the fill's address
    a_r6_write_addr: assert property (@(posedge clk) disable iff (!rst_n)
        cw_valid |-> (cw_addr == $past(fill_addr)));

    // R5: a request just taken is not offered again
    a_r5_once: assert property (@(posedge clk) disable iff (!rst_n)
        (ri_valid && ri_ready) |=> !(ri_valid && ri_addr == $past(ri_addr)));
endmodule

bind sb_coalesce sb_checker #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) u_sb_checker (
    .clk(clk), .rst_n(rst_n), .st_ready(st_ready),
    .ri_valid(ri_valid), .ri_ready(ri_ready), .ri_addr(ri_addr),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .cw_valid(cw_valid), .cw_addr(cw_addr),
    .used_vec(ent_used), .st_hit_vec(st_hit_vec)
);

// File: tb/test_sb_coalesce.sv
`timescale 1ns/1ps
module test_sb_coalesce;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic [3:0]  st_be = '0;
    logic        ri_valid;
    logic        ri_ready = 1'b0;
    logic [31:0] ri_addr;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [31:0] fill_line = '0;
    logic        cw_valid;
    logic [31:0] cw_addr;
    logic [31:0] cw_line;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sb_coalesce i_sb_coalesce (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be),
        .ri_valid(ri_valid), .ri_ready(ri_ready), .ri_addr(ri_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_line(fill_line),
        .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_line(cw_line)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // inputs change on falling edges; one rising edge consumes them
    task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [31:0] a, input logic [31:0] line);
        fill_valid = 1'b1; fill_addr = a; fill_line = line;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic take_request(input string req, input logic [31:0] a);
        chk({req, " request raised"}, 32'(ri_valid), 32'd1);
        chk({req, " request address"}, ri_addr, a);
        ri_ready = 1'b1;
        @(negedge clk);
        ri_ready = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 st_ready", 32'(st_ready), 32'd1);
        chk("R11 ri_valid", 32'(ri_valid), 32'd0);
        chk("R11 cw_valid", 32'(cw_valid), 32'd0);
    endtask

    task automatic t_single_byte;
        do_store(32'h100, 32'h0000005a, 4'b0001);
        take_request("R4", 32'h100);
        chk("R5 no repeat request", 32'(ri_valid), 32'd0);
        do_fill(32'h100, 32'h11223344);
        chk("R6 cw_valid", 32'(cw_valid), 32'd1);
        chk("R6 cw_addr", cw_addr, 32'h100);
        chk("R1 byte overlay", cw_line, 32'h1122335a);
        do_fill(32'h100, 32'h55555555);
        chk("R7 entry freed", 32'(cw_valid), 32'd0);
    endtask

    task automatic t_coalesce;
        do_store(32'h200, 32'h000000aa, 4'b0001);
        take_request("R4", 32'h200);
        do_store(32'h200, 32'h00cc0000, 4'b0100);
        chk("R2 merge raises no request", 32'(ri_valid), 32'd0);
        do_store(32'h200, 32'h000000bb, 4'b0001);
        chk("R2 still no request", 32'(ri_valid), 32'd0);
        do_fill(32'h200, 32'hffffffff);
        chk("R3 replaced byte", cw_line, 32'hffccffbb);
    endtask

    task automatic t_unmatched;
        do_store(32'h300, 32'hdeadbeef, 4'b1111);
        do_fill(32'h304, 32'h12345678);
        chk("R8 unknown fill ignored", 32'(cw_valid), 32'd0);
        do_fill(32'h300, 32'h00000000);
        chk("R8 entry kept", cw_line, 32'hdeadbeef);
        chk("R8 entry kept valid", 32'(cw_valid), 32'd1);
    endtask

    task automatic t_full;
        int n_req;
        logic [31:0] sum;
        for (int i = 0; i < 4; i++) do_store(32'h400 + 32'(i) * 32'h10, 32'h0, 4'b0001);
        st_addr = 32'h440;
        #0.1;
        chk("R9 miss refused when full", 32'(st_ready), 32'd0);
        st_addr = 32'h410;
        #0.1;
        chk("R9 hit taken when full", 32'(st_ready), 32'd1);
        do_store(32'h410, 32'h00007700, 4'b0010);
        n_req = 0; sum = '0;
        ri_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            if (ri_valid) begin n_req++; sum = sum + ri_addr; end
            @(negedge clk);
        end
        ri_ready = 1'b0;
        chk("R5 one request per entry", 32'(n_req), 32'd4);
        chk("R5 requested lines", sum, 32'h1060);
        do_fill(32'h420, 32'h0);
        st_addr = 32'h440;
        #0.1;
        chk("R9 ready after free", 32'(st_ready), 32'd1);
        do_fill(32'h410, 32'h0);
        chk("R9 merged hit while full", cw_line, 32'h00007700);
        do_fill(32'h400, 32'h0);
        do_fill(32'h430, 32'h0);
    endtask

    task automatic t_race;
        do_store(32'h500, 32'h00000001, 4'b0001);
        st_valid = 1'b1; st_addr = 32'h500; st_data = 32'h00000200; st_be = 4'b0010;
        fill_valid = 1'b1; fill_addr = 32'h500; fill_line = 32'ha0a0a0a0;
        @(negedge clk);
        st_valid = 1'b0; fill_valid = 1'b0;
        chk("R10 store before fill", cw_line, 32'ha0a00201);
        do_fill(32'h500, 32'h0);
        chk("R10 no entry left", 32'(cw_valid), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_byte();
        t_coalesce();
        t_unmatched();
        t_full();
        t_race();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule